// File: doc/BRIEF.md
# Power-Good Chained Rail Sequencer

This block brings a board's supply rails up in a fixed order and takes them down in the opposite order. An input-voltage-good flag first has to stay high for a supervisor hold-off before the bulk converter is enabled. Each later core stage is enabled only after the stage below it is enabled and reports power-good. A group of late rails can be switched on by software, but only once every core stage is enabled and good. Examples of late rails are the antenna-array supplies and the clock section.

If a prerequisite is lost, the late group is dropped first. The core stages then drop one per clock, starting with the highest. A core stage that does not report power-good within a set time latches a sticky fault code that names the stage, and everything shuts down until software clears the fault. The requests and the fault clear are plain register bits. The enable vector, the fault code and the power-good inputs together form the status view.

There is no data stream and therefore no valid/ready handshake. Every pin is a level control or status signal, sampled on each clock.

Top module: `rail_seq`

## Requirements
- R1: While reset is asserted and just after it, all core enables, all late enables and the fault code are zero.
- R2: Core stage 0 (the bulk converter) is enabled on the HOLD_CYC+1-th rising clock edge after `vin_good` is first sampled high. Any clock on which `vin_good` is low restarts this hold-off from zero.
- R3: Core stage i (i ≥ 1) is enabled on the clock edge after stage i-1 is enabled and `core_pg[i-1]` is high.
- R4: When a prerequisite is lost, the late enables clear on the next edge. After that, the highest enabled core stage clears on each following edge until no stage is left without its prerequisites.
- R5: If the highest enabled core stage is still waiting for its power-good PG_TMO edges after it was enabled, `fault_code` becomes that stage's index plus one (1 means stage 0). The code stays set, and all stages shut down as in R4.
- R6: Late requests have no effect unless every core stage is enabled and good. Once that holds, `late_en` follows `late_req` one edge later.
- R7: A one-clock `fault_clr` pulse clears a nonzero `fault_code` on the next edge. Bring-up restarts on the edge after that if `vin_good` has stayed high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_good | input | 1 | Input-voltage-good comparator flag |
| core_pg | input | N_CORE | Power-good from each core stage, bit 0 = bulk converter |
| late_req | input | N_LATE | Software requests for the late rails |
| fault_clr | input | 1 | Software write that clears the sticky fault |
| core_en | output | N_CORE | Core stage enables |
| late_en | output | N_LATE | Late rail enables |
| fault_code | output | clog2(N_CORE+1) | 0 = no fault, k = stage k-1 timed out |

## Verification
Each result is registered once, so an input that changes after one edge shows up at the outputs after the next edge. The exceptions are the following. The first enable comes HOLD_CYC+1 edges after `vin_good` rises. A fault comes PG_TMO edges after the stage it names was enabled. A shutdown spreads over one edge for the late group plus one edge for each core stage. The bench drives inputs just after an edge and records, for each expected output, the exact edge count at which it is due. The monitor compares the outputs at the falling edge of that cycle. It also checks the cycle just before each hold-off and timeout expires, so an early change is caught as well as a late one.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  // Position of the highest set bit; zero for an all-zero vector.
  function automatic int unsigned msb_pos(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/rseq_holdoff.sv
module rseq_holdoff #(
  parameter int HOLD_CYC = 11_450_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vin_good,
  output logic sup_ok
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!vin_good)              cnt <= '0;
    else if (cnt != CW'(HOLD_CYC))   cnt <= cnt + 1'b1;
  end

  assign sup_ok = vin_good && (cnt == CW'(HOLD_CYC));
endmodule

// File: rtl/rseq_chain.sv
module rseq_chain
  import rseq_pkg::*;
#(
  parameter int N_CORE = 3,
  localparam int IW = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_ok,
  input  logic              faulted,
  input  logic [N_CORE-1:0] core_pg,
  input  logic              late_busy,
  output logic [N_CORE-1:0] core_en,
  output logic              late_ok,
  output logic              wait_vld,
  output logic [IW-1:0]     wait_idx
);
  logic [N_CORE:0] perm;
  logic [IW-1:0]   top;
  logic            lost;

  always_comb begin
    perm[0] = sup_ok & ~faulted;
    for (int i = 1; i <= N_CORE; i++)
      perm[i] = perm[i-1] & core_en[i-1] & core_pg[i-1];
  end

  assign top     = IW'(msb_pos(32'(core_en)));
  assign lost    = |(core_en & ~perm[N_CORE-1:0]);
  assign late_ok = perm[N_CORE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       core_en <= '0;
    else if (late_busy && !late_ok)   core_en <= core_en;       // late group drops first
    else if (lost)                    core_en[top] <= 1'b0;     // one stage per clock, top down
    else                              core_en <= core_en | (perm[N_CORE-1:0] & ~core_en);
  end

  assign wait_vld = (|core_en) & core_en[top] & ~core_pg[top] & perm[top];
  assign wait_idx = top;
endmodule

// File: rtl/rseq_late.sv
module rseq_late #(
  parameter int N_LATE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              late_ok,
  input  logic [N_LATE-1:0] late_req,
  output logic [N_LATE-1:0] late_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        late_en <= '0;
    else if (!late_ok) late_en <= '0;
    else               late_en <= late_req;
  end
endmodule

// File: rtl/rseq_pgwatch.sv
module rseq_pgwatch #(
  parameter int N_CORE = 3,
  parameter int PG_TMO = 500_000,
  localparam int IW = (N_CORE > 1) ? $clog2(N_CORE) : 1,
  localparam int FW = $clog2(N_CORE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_vld,
  input  logic [IW-1:0] wait_idx,
  input  logic          fault_clr,
  output logic [FW-1:0] fault_code
);
  localparam int TW = $clog2(PG_TMO + 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr        <= '0;
      fault_code <= '0;
    end else if (fault_code != '0) begin
      tmr <= '0;
      if (fault_clr) fault_code <= '0;
    end else if (wait_vld) begin
      if (tmr == TW'(PG_TMO - 1)) begin
        fault_code <= FW'(wait_idx) + 1'b1;
        tmr        <= '0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end else begin
      tmr <= '0;
    end
  end
endmodule

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int N_CORE    = 3,
  parameter int N_LATE    = 6,
  parameter int HOLD_CYC  = 11_450_000,
  parameter int GRANT_CYC = 43_800_000,
  parameter int PG_TMO    = 500_000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vin_good,
  input  logic [N_CORE-1:0]            core_pg,
  input  logic [N_LATE-1:0]            late_req,
  input  logic                         fault_clr,
  output logic [N_CORE-1:0]            core_en,
  output logic [N_LATE-1:0]            late_en,
  output logic [$clog2(N_CORE+1)-1:0]  fault_code
);
  localparam int IW = (N_CORE > 1) ? $clog2(N_CORE) : 1;

  if (HOLD_CYC >= GRANT_CYC) begin : g_bad_hold
    $error("hold-off does not fit inside the upstream power grant window");
  end

  logic          sup_ok;
  logic          late_ok;
  logic          wait_vld;
  logic [IW-1:0] wait_idx;

  rseq_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .vin_good(vin_good), .sup_ok(sup_ok)
  );

  rseq_chain #(.N_CORE(N_CORE)) u_chain (
    .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .faulted(|fault_code),
    .core_pg(core_pg), .late_busy(|late_en), .core_en(core_en),
    .late_ok(late_ok), .wait_vld(wait_vld), .wait_idx(wait_idx)
  );

  rseq_late #(.N_LATE(N_LATE)) u_late (
    .clk(clk), .rst_n(rst_n), .late_ok(late_ok), .late_req(late_req),
    .late_en(late_en)
  );

  rseq_pgwatch #(.N_CORE(N_CORE), .PG_TMO(PG_TMO)) u_watch (
    .clk(clk), .rst_n(rst_n), .wait_vld(wait_vld), .wait_idx(wait_idx),
    .fault_clr(fault_clr), .fault_code(fault_code)
  );
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int N_CORE = 3,
  parameter int N_LATE = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        vin_good,
  input logic [N_CORE-1:0]           core_pg,
  input logic                        fault_clr,
  input logic [N_CORE-1:0]           core_en,
  input logic [N_LATE-1:0]           late_en,
  input logic [$clog2(N_CORE+1)-1:0] fault_code
);
  // R2
  first_stage_needs_vin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en[0]) |-> $past(vin_good));

  for (genvar i = 1; i < N_CORE; i++) begin : g_chain
    // R3
    stage_after_prev_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_en[i]) |-> $past(core_en[i-1] && core_pg[i-1]));
  end

  // R4
  one_stage_per_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(core_en ^ $past(core_en)) <= 1);

  // R6
  late_only_when_core_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|late_en) |-> (&core_en));

  // R5
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != '0 && !fault_clr) |=> (fault_code == $past(fault_code)));
endmodule

bind rail_seq rail_seq_chk #(.N_CORE(N_CORE), .N_LATE(N_LATE)) u_rail_seq_chk (
  .clk(clk), .rst_n(rst_n), .vin_good(vin_good), .core_pg(core_pg),
  .fault_clr(fault_clr), .core_en(core_en), .late_en(late_en),
  .fault_code(fault_code)
);

// File: tb/test_rail_seq.sv
module test_rail_seq;
  localparam int H = 20;
  localparam int T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vin_good = 1'b0;
  logic [2:0] core_pg = '0;
  logic [5:0] late_req = '0;
  logic       fault_clr = 1'b0;
  logic [2:0] core_en;
  logic [5:0] late_en;
  logic [1:0] fault_code;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int         due;
    logic [2:0] core;
    logic [5:0] late;
    logic [1:0] flt;
    string      tag;
  } exp_t;
  exp_t q[$];

  rail_seq #(.N_CORE(3), .N_LATE(6), .HOLD_CYC(H), .GRANT_CYC(4 * H), .PG_TMO(T)) i_rail_seq (
    .clk(clk), .rst_n(rst_n), .vin_good(vin_good), .core_pg(core_pg),
    .late_req(late_req), .fault_clr(fault_clr), .core_en(core_en),
    .late_en(late_en), .fault_code(fault_code)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_exp(input int d, input logic [2:0] c, input logic [5:0] l,
                          input logic [1:0] f, input string tag);
    exp_t e;
    e.due = cyc + d; e.core = c; e.late = l; e.flt = f; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare each expected item at its due cycle
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      n_chk++;
      if (e.due != cyc || core_en !== e.core || late_en !== e.late || fault_code !== e.flt) begin
        n_fail++;
        $display("FAIL %s cyc %0d: core_en=%b late_en=%b fault=%0d expected core_en=%b late_en=%b fault=%0d",
                 e.tag, cyc, core_en, late_en, fault_code, e.core, e.late, e.flt);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    push_exp(0, 3'b000, 6'h00, 2'd0, "R1 in reset");
    tick(1);
    rst_n = 1'b1;
    push_exp(1, 3'b000, 6'h00, 2'd0, "R1 after reset");
    tick(2);

    // first bring-up, requests held back until core is good
    vin_good = 1'b1;
    push_exp(H,     3'b000, 6'h00, 2'd0, "R2 before hold-off");
    push_exp(H + 1, 3'b001, 6'h00, 2'd0, "R2 hold-off done");
    tick(H + 1);
    late_req = 6'h3F; core_pg = 3'b001;
    push_exp(1, 3'b011, 6'h00, 2'd0, "R3 stage1 / R6 ignored");
    tick(1);
    core_pg = 3'b011;
    push_exp(1, 3'b111, 6'h00, 2'd0, "R3 stage2 / R6 ignored");
    tick(1);
    core_pg = 3'b111;
    push_exp(1, 3'b111, 6'h3F, 2'd0, "R6 late follow");
    tick(1);
    late_req = 6'h05;
    push_exp(1, 3'b111, 6'h05, 2'd0, "R6 late change");
    tick(1);

    // loss of input: reverse order
    vin_good = 1'b0;
    push_exp(1, 3'b111, 6'h00, 2'd0, "R4 late first");
    push_exp(2, 3'b011, 6'h00, 2'd0, "R4 stage2 off");
    push_exp(3, 3'b001, 6'h00, 2'd0, "R4 stage1 off");
    push_exp(4, 3'b000, 6'h00, 2'd0, "R4 stage0 off");
    tick(4);

    // fast re-bring-up with all power-goods already high
    vin_good = 1'b1;
    push_exp(H,     3'b000, 6'h00, 2'd0, "R2 restart hold");
    push_exp(H + 1, 3'b001, 6'h00, 2'd0, "R2 restart");
    push_exp(H + 2, 3'b011, 6'h00, 2'd0, "R3 chain");
    push_exp(H + 3, 3'b111, 6'h00, 2'd0, "R3 chain top");
    push_exp(H + 4, 3'b111, 6'h05, 2'd0, "R6 late after core");
    tick(H + 4);
    vin_good = 1'b0; late_req = 6'h00; core_pg = 3'b000;
    push_exp(4, 3'b000, 6'h00, 2'd0, "R4 full drop");
    tick(4);

    // glitch on vin restarts the hold-off, then stage 0 times out
    vin_good = 1'b1; tick(5);
    vin_good = 1'b0; tick(1);
    vin_good = 1'b1;
    push_exp(H,         3'b000, 6'h00, 2'd0, "R2 glitch restart");
    push_exp(H + 1,     3'b001, 6'h00, 2'd0, "R2 enable after glitch");
    push_exp(H + T,     3'b001, 6'h00, 2'd0, "R5 no early fault");
    push_exp(H + T + 1, 3'b001, 6'h00, 2'd1, "R5 stage0 fault");
    push_exp(H + T + 2, 3'b000, 6'h00, 2'd1, "R5 shutdown on fault");
    tick(H + T + 2);
    core_pg = 3'b001;
    push_exp(3, 3'b000, 6'h00, 2'd1, "R5 sticky");
    tick(3);

    // clear, restart, stage 1 times out
    fault_clr = 1'b1;
    push_exp(1,     3'b000, 6'h00, 2'd0, "R7 cleared");
    push_exp(2,     3'b001, 6'h00, 2'd0, "R7 restart");
    push_exp(3,     3'b011, 6'h00, 2'd0, "R3 after clear");
    push_exp(2 + T, 3'b011, 6'h00, 2'd0, "R5 no early fault");
    push_exp(3 + T, 3'b011, 6'h00, 2'd2, "R5 stage1 fault");
    push_exp(4 + T, 3'b001, 6'h00, 2'd2, "R4 fault drop");
    push_exp(5 + T, 3'b000, 6'h00, 2'd2, "R4 fault drop end");
    tick(1);
    fault_clr = 1'b0;
    tick(4 + T);

    tick(3);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule